// File: doc/BRIEF.md
# Address Break Comparator Unit

This block is a debug watchpoint for a small 16-bit microcontroller bus. Software programs a 16-bit break address, an optional 16-bit compare value and a control byte that chooses which kind of bus cycle to watch. The kinds are instruction fetch (execute), data read, data write, or either data kind. The block then observes every bus cycle. For an execute break the watched address is the address of the instruction's first byte.

For data cycles the block can also require a data match. The value it compares is taken from the byte lane that the access really uses. That lane depends on byte or word size, on the address parity, and on whether the accessed region has an 8-bit or a 16-bit data bus. A word access to an 8-bit region reaches the bus as two byte beats, each on the upper lane, and each beat is judged as a byte access.

A match sets a sticky flag. Software can clear the flag only by reading it as 1 and then writing 0 to it. An interrupt request is raised while the flag and its enable are both set.

Top module: `addr_watch_unit`

## Requirements
- R1: After reset, the address bytes read 0xFF (select 0 high byte, select 1 low byte), the compare bytes read 0x00 (select 2 high, select 3 low), control (select 4) reads 0x00, status (select 5) reads 0x3F, selects 6 and 7 read 0x00, and irq is 0.
- R2: With control mode 0 (execute), only a bus cycle with kind 0 (fetch) whose address equals the break address sets the flag; kind 1 (read) and kind 2 (write) cycles at that address do not.
- R3: Control bits [1:0] choose the watched kind: 1 read, 2 write, 3 read or write. Control bit 2 enables the data compare. In execute mode the data compare enable has no effect. Unused control bits read back as 0.
- R4: In a 16-bit region (bus_narrow=0), a byte access at an even address compares bus_data[15:8] with the low compare byte, and one at an odd address compares bus_data[7:0] with it.
- R5: In a 16-bit region, a word access compares all 16 bits of bus_data with the 16-bit compare value.
- R6: In an 8-bit region (bus_narrow=1), every beat is treated as a byte access on bus_data[15:8], including beats flagged as word (bus_word=1).
- R7: The flag (status bit 7) becomes 1 on the clock edge that ends the matching cycle and stays 1 until it is cleared.
- R8: A status write with bit 7 equal to 0 clears the flag only if a status read (reg_rd with select 5) returned the flag as 1 earlier and no clearing write has happened since. A write of 0 without that read leaves the flag set. Writing 1 to bit 7 never sets the flag.
- R9: When a match and a clearing write fall in the same cycle, the flag stays 1, and a later write of 0 needs a fresh read before it can clear the flag.
- R10: Status bit 6 is the interrupt enable and is written by every status write. irq is 1 exactly when the flag and the enable are both 1.
- R11: Status bits 5 to 0 always read as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_sel | input | 3 | Register select for the read and write port |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_rd | input | 1 | Read strobe, used to arm the status clear |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_kind | input | 2 | 0 fetch, 1 data read, 2 data write |
| bus_addr | input | 16 | Byte address of the cycle |
| bus_word | input | 1 | 1 for a word access, 0 for a byte access |
| bus_narrow | input | 1 | 1 when the accessed region has an 8-bit data bus |
| bus_data | input | 16 | Bus data, upper lane in bits 15:8 |
| irq | output | 1 | Address break interrupt request |

## Verification
Two events can land in the same clock: a new match, and the status write that clears the flag. The bench first sets the flag and reads status, which arms the clear. In the next cycle it drives a matching bus cycle together with a status write of 0. The flag must still read 1 afterwards. A following write of 0 made without a new read must leave the flag set, which shows that the armed state was used up by the colliding write. A behavioural model in the bench applies the same priority on every clock and is compared with reg_rdata and irq.

// File: rtl/abw_pkg.sv
package abw_pkg;

  localparam int ABW_ADDR_W = 16;
  localparam int ABW_DATA_W = 16;
  localparam int ABW_LANE_W = ABW_DATA_W / 2;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'd0,
    KIND_READ  = 2'd1,
    KIND_WRITE = 2'd2,
    KIND_RSVD  = 2'd3
  } bus_kind_e;

  typedef enum logic [1:0] {
    WATCH_EXEC  = 2'd0,
    WATCH_READ  = 2'd1,
    WATCH_WRITE = 2'd2,
    WATCH_RW    = 2'd3
  } watch_e;

  typedef enum logic [1:0] {
    LANE_UPPER = 2'd0,
    LANE_LOWER = 2'd1,
    LANE_BOTH  = 2'd2
  } lane_e;

  localparam logic [2:0] SEL_ADDR_HI = 3'd0;
  localparam logic [2:0] SEL_ADDR_LO = 3'd1;
  localparam logic [2:0] SEL_DATA_HI = 3'd2;
  localparam logic [2:0] SEL_DATA_LO = 3'd3;
  localparam logic [2:0] SEL_CTRL    = 3'd4;
  localparam logic [2:0] SEL_STATUS  = 3'd5;

  // Lane used by an access: 8-bit regions always use the upper lane.
  function automatic lane_e pick_lane(logic word, logic narrow, logic addr0);
    if (narrow)     return LANE_UPPER;
    else if (word)  return LANE_BOTH;
    else if (addr0) return LANE_LOWER;
    else            return LANE_UPPER;
  endfunction

  function automatic logic kind_hits(watch_e mode, logic [1:0] kind);
    case (mode)
      WATCH_EXEC:  return kind == KIND_FETCH;
      WATCH_READ:  return kind == KIND_READ;
      WATCH_WRITE: return kind == KIND_WRITE;
      default:     return (kind == KIND_READ) || (kind == KIND_WRITE);
    endcase
  endfunction

  function automatic logic data_hits(lane_e lane,
                                     logic [ABW_DATA_W-1:0] bus,
                                     logic [ABW_DATA_W-1:0] ref_val);
    case (lane)
      LANE_BOTH:  return bus == ref_val;
      LANE_LOWER: return bus[ABW_LANE_W-1:0] == ref_val[ABW_LANE_W-1:0];
      default:    return bus[ABW_DATA_W-1:ABW_LANE_W] == ref_val[ABW_LANE_W-1:0];
    endcase
  endfunction

endpackage

// File: rtl/abw_regs.sv
module abw_regs
  import abw_pkg::*;
#(
  parameter int ADDR_W = ABW_ADDR_W,
  parameter int DATA_W = ABW_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        sel,
  input  logic              wr,
  input  logic [7:0]        wdata,
  input  logic              flag,
  output logic [7:0]        rdata,
  output logic [ADDR_W-1:0] brk_addr,
  output logic [DATA_W-1:0] brk_data,
  output watch_e            mode,
  output logic              dcmp_en,
  output logic              irq_en,
  output logic              status_wr
);

  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int DATA_BYTES = DATA_W / 8;

  // Address bytes: the high byte sits at the lower select value.
  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_addr
    localparam logic [2:0] MY_SEL = SEL_ADDR_HI + 3'(ADDR_BYTES - 1 - g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   brk_addr[g*8 +: 8] <= 8'hFF;
      else if (wr && sel == MY_SEL) brk_addr[g*8 +: 8] <= wdata;
    end
  end

  for (genvar g = 0; g < DATA_BYTES; g++) begin : g_data
    localparam logic [2:0] MY_SEL = SEL_DATA_HI + 3'(DATA_BYTES - 1 - g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   brk_data[g*8 +: 8] <= 8'h00;
      else if (wr && sel == MY_SEL) brk_data[g*8 +: 8] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= WATCH_EXEC;
      dcmp_en <= 1'b0;
    end else if (wr && sel == SEL_CTRL) begin
      mode    <= watch_e'(wdata[1:0]);
      dcmp_en <= wdata[2];
    end
  end

  assign status_wr = wr && (sel == SEL_STATUS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         irq_en <= 1'b0;
    else if (status_wr) irq_en <= wdata[6];
  end

  always_comb begin
    case (sel)
      SEL_ADDR_HI: rdata = brk_addr[ADDR_W-1 -: 8];
      SEL_ADDR_LO: rdata = brk_addr[7:0];
      SEL_DATA_HI: rdata = brk_data[DATA_W-1 -: 8];
      SEL_DATA_LO: rdata = brk_data[7:0];
      SEL_CTRL:    rdata = {5'b0, dcmp_en, mode};
      SEL_STATUS:  rdata = {flag, irq_en, 6'h3F};
      default:     rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/abw_match.sv
module abw_match
  import abw_pkg::*;
#(
  parameter int ADDR_W = ABW_ADDR_W,
  parameter int DATA_W = ABW_DATA_W
) (
  input  logic              bus_valid,
  input  logic [1:0]        bus_kind,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_word,
  input  logic              bus_narrow,
  input  logic [DATA_W-1:0] bus_data,
  input  logic [ADDR_W-1:0] brk_addr,
  input  logic [DATA_W-1:0] brk_data,
  input  watch_e            mode,
  input  logic              dcmp_en,
  output lane_e             lane,
  output logic              hit
);

  logic kind_ok, addr_ok, data_ok, data_needed;

  assign lane        = pick_lane(bus_word, bus_narrow, bus_addr[0]);
  assign kind_ok     = kind_hits(mode, bus_kind);
  assign addr_ok     = bus_addr == brk_addr;
  assign data_needed = dcmp_en && (mode != WATCH_EXEC);
  assign data_ok     = !data_needed || data_hits(lane, bus_data, brk_data);
  assign hit         = bus_valid && kind_ok && addr_ok && data_ok;

endmodule

// File: rtl/abw_flag.sv
module abw_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic status_rd,
  input  logic status_wr,
  input  logic wbit7,
  output logic flag,
  output logic seen,
  output logic clr_evt
);

  assign clr_evt = status_wr && !wbit7 && seen;

  // A match wins over a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (hit)     flag <= 1'b1;
    else if (clr_evt) flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 seen <= 1'b0;
    else if (clr_evt)           seen <= 1'b0;
    else if (status_rd && flag) seen <= 1'b1;
  end

endmodule

// File: rtl/addr_watch_unit.sv
module addr_watch_unit
  import abw_pkg::*;
#(
  parameter int ADDR_W = ABW_ADDR_W,
  parameter int DATA_W = ABW_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        reg_sel,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              bus_valid,
  input  logic [1:0]        bus_kind,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_word,
  input  logic              bus_narrow,
  input  logic [DATA_W-1:0] bus_data,
  output logic              irq
);

  logic [ADDR_W-1:0] brk_addr;
  logic [DATA_W-1:0] brk_data;
  watch_e            mode;
  logic              dcmp_en, irq_en, status_wr, status_rd;
  logic              hit, flag, seen, clr_evt;
  lane_e             lane;

  assign status_rd = reg_rd && (reg_sel == SEL_STATUS);

  abw_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .sel(reg_sel), .wr(reg_wr), .wdata(reg_wdata),
    .flag(flag), .rdata(reg_rdata), .brk_addr(brk_addr), .brk_data(brk_data),
    .mode(mode), .dcmp_en(dcmp_en), .irq_en(irq_en), .status_wr(status_wr)
  );

  abw_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) match_i (
    .bus_valid(bus_valid), .bus_kind(bus_kind), .bus_addr(bus_addr),
    .bus_word(bus_word), .bus_narrow(bus_narrow), .bus_data(bus_data),
    .brk_addr(brk_addr), .brk_data(brk_data), .mode(mode), .dcmp_en(dcmp_en),
    .lane(lane), .hit(hit)
  );

  abw_flag flag_i (
    .clk(clk), .rst_n(rst_n), .hit(hit), .status_rd(status_rd),
    .status_wr(status_wr), .wbit7(reg_wdata[7]), .flag(flag), .seen(seen),
    .clr_evt(clr_evt)
  );

  assign irq = flag && irq_en;

endmodule

// File: rtl/abw_chk.sv
module abw_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hit,
  input logic       clr_evt,
  input logic       seen,
  input logic       flag,
  input logic       irq,
  input logic       irq_en,
  input logic       status_wr,
  input logic       wbit7,
  input logic [2:0] reg_sel,
  input logic [7:0] reg_rdata
);

  // R7
  hit_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);

  // R7
  flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(hit));

  // R8
  blind_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_wr && !wbit7 && !seen && flag) |=> flag);

  // R9
  match_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && clr_evt) |=> (flag && !seen));

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag || !irq_en) |-> !irq);

  // R11
  status_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == 3'd5) |-> (reg_rdata[5:0] == 6'h3F));

endmodule

bind addr_watch_unit abw_chk chk_i (
  .clk(clk), .rst_n(rst_n), .hit(hit), .clr_evt(clr_evt), .seen(seen),
  .flag(flag), .irq(irq), .irq_en(irq_en), .status_wr(status_wr),
  .wbit7(reg_wdata[7]), .reg_sel(reg_sel), .reg_rdata(reg_rdata)
);

// File: tb/addr_watch_unit_tb_top.sv
module addr_watch_unit_tb_top;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [2:0]  reg_sel = 0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [7:0]  reg_wdata = 0;
  logic [7:0]  reg_rdata;
  logic        bus_valid = 0;
  logic [1:0]  bus_kind = 0;
  logic [15:0] bus_addr = 0;
  logic        bus_word = 0, bus_narrow = 0;
  logic [15:0] bus_data = 0;
  logic        irq;

  int checks = 0, failures = 0, cycles = 0;
  string phase = "R1";

  always #10 clk = ~clk;

  addr_watch_unit dut_i (.*);

  // Behavioural reference model
  int m_addr, m_data, m_mode, m_dce;
  bit m_en, m_flag, m_seen;

  function automatic bit model_hit();
    int k, b;
    bit kind_ok;
    if (!bus_valid) return 0;
    k = int'(bus_kind);
    kind_ok = (m_mode == 0) ? (k == 0) :
              (m_mode == 1) ? (k == 1) :
              (m_mode == 2) ? (k == 2) : (k == 1 || k == 2);
    if (!kind_ok || int'(bus_addr) != m_addr) return 0;
    if (m_mode == 0 || m_dce == 0) return 1;
    if (bus_word && !bus_narrow) return int'(bus_data) == m_data;
    if (bus_narrow || bus_addr % 2 == 0) b = int'(bus_data) / 256;
    else b = int'(bus_data) % 256;
    return b == m_data % 256;
  endfunction

  function automatic int model_rd(int s);
    case (s)
      0: return m_addr / 256;
      1: return m_addr % 256;
      2: return m_data / 256;
      3: return m_data % 256;
      4: return m_dce * 4 + m_mode;
      5: return (m_flag ? 128 : 0) + (m_en ? 64 : 0) + 63;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_addr = 16'hFFFF; m_data = 0; m_mode = 0; m_dce = 0;
      m_en = 0; m_flag = 0; m_seen = 0;
    end else begin
      bit h, clr, nflag, nseen;
      h = model_hit();
      clr = reg_wr && reg_sel == 5 && !reg_wdata[7] && m_seen;
      nflag = h || (m_flag && !clr);
      nseen = clr ? 0 : (m_seen || (reg_rd && reg_sel == 5 && m_flag));
      if (reg_wr) begin
        case (int'(reg_sel))
          0: m_addr = int'(reg_wdata) * 256 + m_addr % 256;
          1: m_addr = (m_addr / 256) * 256 + int'(reg_wdata);
          2: m_data = int'(reg_wdata) * 256 + m_data % 256;
          3: m_data = (m_data / 256) * 256 + int'(reg_wdata);
          4: begin m_mode = int'(reg_wdata) % 4; m_dce = (int'(reg_wdata) / 4) % 2; end
          5: m_en = reg_wdata[6];
          default: ;
        endcase
      end
      m_flag = nflag; m_seen = nseen;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // One clock with the current inputs, then compare at the falling edge.
  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    chk(int'(reg_rdata) == model_rd(int'(reg_sel)), {phase, " rdata"},
        int'(reg_rdata), model_rd(int'(reg_sel)));
    chk(irq == (m_flag && m_en), {phase, " irq"}, int'(irq), int'(m_flag && m_en));
  endtask

  task automatic wr_reg(int s, int v);
    reg_sel = 3'(s); reg_wdata = 8'(v); reg_wr = 1; cyc(); reg_wr = 0;
  endtask

  task automatic rd_reg(int s);
    reg_sel = 3'(s); reg_rd = 1; cyc(); reg_rd = 0;
  endtask

  // Observe a register through the combinational read path without arming.
  task automatic peek(int s, int exp, string req);
    reg_sel = 3'(s); cyc();
    chk(int'(reg_rdata) == exp, req, int'(reg_rdata), exp);
  endtask

  task automatic bus(int kind, int addr, int data, bit word, bit narrow);
    bus_valid = 1; bus_kind = 2'(kind); bus_addr = 16'(addr);
    bus_data = 16'(data); bus_word = word; bus_narrow = narrow;
    cyc(); bus_valid = 0;
  endtask

  task automatic clear_flag(int en_bits);
    rd_reg(5); wr_reg(5, en_bits);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    phase = "R1";
    peek(0, 8'hFF, "R1 addr hi"); peek(1, 8'hFF, "R1 addr lo");
    peek(2, 0, "R1 data hi"); peek(3, 0, "R1 data lo");
    peek(4, 0, "R1 ctrl"); peek(5, 8'h3F, "R1 status");
    peek(6, 0, "R1 unused select"); peek(7, 0, "R1 unused select");
    chk(irq == 0, "R1 irq", int'(irq), 0);

    // R2 execute mode
    phase = "R2";
    wr_reg(0, 8'h12); wr_reg(1, 8'h34);
    bus(0, 16'h1236, 0, 0, 0); peek(5, 8'h3F, "R2 fetch other addr");
    bus(1, 16'h1234, 0, 0, 0); peek(5, 8'h3F, "R2 read ignored");
    bus(2, 16'h1234, 0, 0, 0); peek(5, 8'h3F, "R2 write ignored");
    phase = "R7";
    bus(0, 16'h1234, 0, 0, 0); peek(5, 8'hBF, "R7 flag after fetch match");
    peek(5, 8'hBF, "R7 flag sticky");

    // R8 clear protocol
    phase = "R8";
    wr_reg(5, 8'h00); peek(5, 8'hBF, "R8 blind write keeps flag");
    wr_reg(5, 8'h80); peek(5, 8'hBF, "R8 write one no effect");
    clear_flag(0); peek(5, 8'h3F, "R8 read then write clears");
    wr_reg(5, 8'h80); peek(5, 8'h3F, "R8 write one never sets");

    // R10 interrupt enable
    phase = "R10";
    wr_reg(5, 8'h40); peek(5, 8'h7F, "R10 enable only");
    chk(irq == 0, "R10 no irq without flag", int'(irq), 0);
    bus(0, 16'h1234, 0, 0, 0);
    chk(irq == 1, "R10 irq with flag and enable", int'(irq), 1);
    wr_reg(5, 8'h00);
    chk(irq == 0, "R10 irq off when enable cleared", int'(irq), 0);
    clear_flag(0);

    // R3 execute ignores data compare
    phase = "R3";
    wr_reg(4, 8'h04); wr_reg(3, 8'hAB);
    peek(4, 8'h04, "R3 ctrl readback");
    wr_reg(4, 8'hFC); peek(4, 8'h04, "R3 unused ctrl bits zero");
    bus(0, 16'h1234, 16'h0000, 0, 0); peek(5, 8'hBF, "R3 exec ignores data");
    clear_flag(0);

    // R4 lane choice in 16-bit region, read mode with data compare
    phase = "R4";
    wr_reg(4, 8'h05);
    bus(1, 16'h1234, 16'h00AB, 0, 0); peek(5, 8'h3F, "R4 even uses upper lane");
    bus(1, 16'h1234, 16'hAB00, 0, 0); peek(5, 8'hBF, "R4 even upper hit");
    clear_flag(0);
    wr_reg(1, 8'h35);
    bus(1, 16'h1235, 16'hAB00, 0, 0); peek(5, 8'h3F, "R4 odd ignores upper lane");
    bus(1, 16'h1235, 16'h00AB, 0, 0); peek(5, 8'hBF, "R4 odd lower hit");
    clear_flag(0);

    // R6 narrow region: upper lane even for word beats at odd address
    phase = "R6";
    bus(1, 16'h1235, 16'h00AB, 1, 1); peek(5, 8'h3F, "R6 narrow ignores lower lane");
    bus(1, 16'h1235, 16'hAB00, 1, 1); peek(5, 8'hBF, "R6 narrow word beat upper");
    clear_flag(0);

    // R5 word compare
    phase = "R5";
    wr_reg(1, 8'h34); wr_reg(2, 8'hBE); wr_reg(3, 8'hEF);
    bus(1, 16'h1234, 16'hBEEE, 1, 0); peek(5, 8'h3F, "R5 word mismatch");
    bus(1, 16'h1234, 16'hBEEF, 1, 0); peek(5, 8'hBF, "R5 word full match");
    clear_flag(0);

    // R3 write and read-or-write modes
    phase = "R3";
    wr_reg(4, 8'h02);
    bus(1, 16'h1234, 0, 0, 0); peek(5, 8'h3F, "R3 write mode ignores read");
    bus(0, 16'h1234, 0, 0, 0); peek(5, 8'h3F, "R3 write mode ignores fetch");
    bus(2, 16'h1234, 0, 0, 0); peek(5, 8'hBF, "R3 write mode hit");
    clear_flag(0);
    wr_reg(4, 8'h03);
    bus(1, 16'h1234, 0, 0, 0); peek(5, 8'hBF, "R3 rw mode read hit");
    clear_flag(0);
    bus(2, 16'h1234, 0, 0, 0); peek(5, 8'hBF, "R3 rw mode write hit");
    clear_flag(0);

    // R9 match and clearing write together
    phase = "R9";
    bus(2, 16'h1234, 0, 0, 0);
    rd_reg(5);
    bus_valid = 1; bus_kind = 2; bus_addr = 16'h1234;
    reg_sel = 5; reg_wdata = 0; reg_wr = 1;
    cyc();
    reg_wr = 0; bus_valid = 0;
    peek(5, 8'hBF, "R9 match wins over clear");
    wr_reg(5, 8'h00); peek(5, 8'hBF, "R9 armed state consumed");
    clear_flag(0); peek(5, 8'h3F, "R9 fresh read clears");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule